// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Transmitter

This block sends one infrared remote-control frame, and its repeats, as a train of marks and spaces. A mark has the carrier switched on and a space has it switched off. Every length is counted in ticks of a slow strobe, nominally 10 kHz, that the surrounding logic supplies on `tick`. A host loads a packed bit buffer and one protocol's timing set, then pulses `start`. The engine captures the buffer and the timing set, raises `busy`, and works through the frame. It sends an optional start bit, the data bits in buffer order and an optional stop bit. It then waits a gap with the carrier off and sends the next repeat, until the configured number of frames has gone out.

Two special frame modes cover common protocol families. Sync mode inserts an extra bit after the 16 address bits. Double mode sends a second frame that skips the start bit and resumes the buffer at bit 16, so that a second copy of the payload can follow after a long gap. `carrier_en` gates a square wave taken from a clock divider, and `ir_out` is the gated carrier that drives the LED driver.

Top module: `ir_pd_tx`

## Requirements
- R1: After a synchronous reset, and whenever `rst` is asserted during a frame, `busy`, `carrier_en` and `ir_out` are 0. The engine then waits for a new `start`.
- R2: `carrier_en` changes only in the clock cycle after a cycle with `tick` high. A bit with mark length M and space length S gives exactly M ticks with `carrier_en`=1 followed by S ticks with `carrier_en`=0. Every data, sync and stop length is at least 1.
- R3: A frame opens with a start bit that uses `start_mark`/`start_space`. When `start_mark` is 0, the start bit is omitted and the frame begins with data bit 0.
- R4: Data bit i is `frame_bits[39-i]`, so byte 0 sits in bits 39:32 and is sent MSB first. Bits 0 to `bit_count`-1 are sent. A 1 uses `one_mark`/`one_space` and a 0 uses `zero_mark`/`zero_space`.
- R5: With `stop_en`=1, a stop bit follows the data. It has mark `zero_mark` and, on frames other than the last, space `zero_space`.
- R6: On the final frame, the stop bit's space is 255 ticks.
- R7: `rep_count` frames are sent, with values 0 and 1 both meaning one frame. Between frames the carrier is off for `rep_gap` ticks. A repeat that is not in double mode again starts with the start bit. `busy` falls in the cycle after the last tick of the final frame.
- R8: In sync mode, index 16 is a sync bit with mark `zero_mark` and space `start_space`. Indexes above 16 read buffer bit index-1. The frame still ends at index `bit_count`.
- R9: In double mode, every frame after the first has no start bit. It sends indexes 16 to 2·`bit_count` and then the stop bit if `stop_en` is set.
- R10: A `start` pulse while `busy` is 1 is ignored. Buffer and timing inputs are captured when a frame is accepted, and later changes have no effect on the frame in flight.
- R11: While `carrier_en` is 1, `ir_out` is a square wave whose level toggles every `carrier_div`+1 clocks, starting low. While `carrier_en` is 0, `ir_out` is 0.
- R12: `start` with `busy`=0 raises `busy` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle bit-timing strobe |
| start | input | 1 | Frame start strobe |
| frame_bits | input | 40 | Packed bit buffer, byte 0 in the top byte |
| start_mark | input | 8 | Start-bit mark ticks (0 omits the start bit) |
| start_space | input | 8 | Start-bit space ticks, also the sync space |
| one_mark | input | 8 | Mark ticks for a 1 |
| one_space | input | 8 | Space ticks for a 1 |
| zero_mark | input | 8 | Mark ticks for a 0, the sync bit and the stop bit |
| zero_space | input | 8 | Space ticks for a 0 and a non-final stop bit |
| bit_count | input | 7 | Data bits per frame |
| stop_en | input | 1 | Append a stop bit |
| rep_count | input | 2 | Frames to send |
| rep_gap | input | 16 | Ticks of silence between frames |
| sync_mode | input | 1 | Insert a sync bit after 16 address bits |
| dbl_mode | input | 1 | Repeats resume at buffer bit 16 |
| carrier_div | input | 8 | Carrier half period minus one, in clocks |
| busy | output | 1 | Frame sequence in progress |
| carrier_en | output | 1 | Carrier gate (1 during a mark) |
| ir_out | output | 1 | Gated carrier output |

## Verification
The bench drives several frames and compares `carrier_en` tick by tick against a mark/space list built from the requirements. The first frame uses a plain start bit with data and no stop bit, which separates the 1 and 0 lengths and the bit order. A frame without a start bit but with a stop bit shows the omission and the 255-tick trailer. A three-frame run shows the gap and the difference between the normal and stretched stop spaces. A sync frame and a double-mode pair show the sync insertion, the index-1 reads and the resume at bit 16. A start pulse and altered inputs injected in the middle of a frame must leave the waveform unchanged. A long mark, measured clock by clock, shows the carrier half period, and a reset during that mark shows that the engine returns to idle.

// File: rtl/ir_pd_pkg.sv
package ir_pd_pkg;

    localparam int BUF_BYTES = 5;
    localparam int BUF_W     = BUF_BYTES * 8;
    localparam int LEN_W     = 8;
    localparam int GAP_W     = 16;
    localparam int REP_W     = 2;
    localparam int IDX_W     = $clog2(2 * BUF_W + 2);
    localparam int SYNC_AT   = 16;
    localparam int TRAILER   = 255;
    localparam logic [IDX_W-1:0] IDX_IDLE = '1;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_MARK,
        PH_SPACE,
        PH_GAP
    } phase_t;

    typedef struct packed {
        logic [LEN_W-1:0] mark;
        logic [LEN_W-1:0] space;
    } seg_t;

    typedef struct packed {
        logic [BUF_W-1:0] bits;
        seg_t             lead;
        seg_t             one;
        seg_t             zero;
        logic [IDX_W-1:0] nbits;
        logic             stop;
        logic [REP_W-1:0] reps;
        logic [GAP_W-1:0] gap;
        logic             sync;
        logic             dbl;
    } frame_cfg_t;

    // Buffer index j reads the j-th bit counted from the MSB.
    function automatic logic buf_bit(input logic [BUF_W-1:0] b,
                                     input logic [IDX_W-1:0] j);
        logic [BUF_W-1:0] sh;
        sh = b << j;
        return sh[BUF_W-1];
    endfunction

endpackage

// File: rtl/ir_pd_seg_sel.sv
module ir_pd_seg_sel
    import ir_pd_pkg::*;
(
    input  frame_cfg_t       cfg,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] end_idx,
    input  logic             final_frame,
    output seg_t             seg
);
    logic [IDX_W-1:0] rd_idx;
    logic             val;

    always_comb begin
        rd_idx = (cfg.sync && idx > IDX_W'(SYNC_AT)) ? idx - 1'b1 : idx;
        val    = buf_bit(cfg.bits, rd_idx);
        if (idx == IDX_IDLE) begin
            seg = cfg.lead;
        end else if (idx < end_idx) begin
            if (cfg.sync && idx == IDX_W'(SYNC_AT))
                seg = '{mark: cfg.zero.mark, space: cfg.lead.space};
            else
                seg = val ? cfg.one : cfg.zero;
        end else begin
            seg.mark  = cfg.zero.mark;
            seg.space = final_frame ? LEN_W'(TRAILER) : cfg.zero.space;
        end
    end
endmodule

// File: rtl/ir_pd_seq.sv
module ir_pd_seq
    import ir_pd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start,
    input  frame_cfg_t cfg_in,
    output logic       busy,
    output logic       carrier_en
);
    phase_t           phase;
    frame_cfg_t       cfg;
    logic [IDX_W-1:0] idx, end_idx;
    logic [GAP_W-1:0] cnt;
    logic [REP_W-1:0] rep;
    logic             car;
    seg_t             seg;

    logic             final_frame, last_bit;
    logic [GAP_W:0]   cnt_nxt, seg_len, gap_len;
    logic [IDX_W:0]   next_idx, stop_lim;

    ir_pd_seg_sel u_sel (
        .cfg        (cfg),
        .idx        (idx),
        .end_idx    (end_idx),
        .final_frame(final_frame),
        .seg        (seg)
    );

    always_comb begin
        final_frame = ({1'b0, rep} + 1'b1) >= {1'b0, cfg.reps};
        cnt_nxt     = {1'b0, cnt} + 1'b1;
        seg_len     = (GAP_W+1)'((phase == PH_MARK) ? seg.mark : seg.space);
        gap_len     = {1'b0, cfg.gap};
        next_idx    = (idx == IDX_IDLE) ? '0 : {1'b0, idx} + 1'b1;
        stop_lim    = {1'b0, end_idx} + {{IDX_W{1'b0}}, cfg.stop};
        last_bit    = (idx != IDX_IDLE) && (next_idx >= stop_lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cfg     <= '0;
            idx     <= IDX_IDLE;
            end_idx <= '0;
            cnt     <= '0;
            rep     <= '0;
            car     <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        cfg     <= cfg_in;
                        idx     <= (cfg_in.lead.mark != '0) ? IDX_IDLE : '0;
                        end_idx <= cfg_in.nbits;
                        cnt     <= '0;
                        rep     <= '0;
                        phase   <= PH_MARK;
                    end
                end
                PH_MARK, PH_SPACE: begin
                    if (tick) begin
                        car <= (phase == PH_MARK);
                        if (cnt_nxt < seg_len) begin
                            cnt <= cnt_nxt[GAP_W-1:0];
                        end else begin
                            cnt <= '0;
                            if (phase == PH_MARK) begin
                                phase <= PH_SPACE;
                            end else if (!last_bit) begin
                                idx   <= next_idx[IDX_W-1:0];
                                phase <= PH_MARK;
                            end else begin
                                idx <= IDX_IDLE;
                                if (final_frame) begin
                                    rep   <= '0;
                                    phase <= PH_IDLE;
                                end else begin
                                    rep   <= rep + 1'b1;
                                    phase <= PH_GAP;
                                end
                            end
                        end
                    end
                end
                PH_GAP: begin
                    if (tick) begin
                        car <= 1'b0;
                        if (cnt_nxt < gap_len) begin
                            cnt <= cnt_nxt[GAP_W-1:0];
                        end else begin
                            cnt   <= '0;
                            phase <= PH_MARK;
                            if (cfg.dbl) begin
                                idx     <= IDX_W'(SYNC_AT);
                                end_idx <= {cfg.nbits[IDX_W-2:0], 1'b1};
                            end else begin
                                idx <= (cfg.lead.mark != '0) ? IDX_IDLE : '0;
                            end
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy       = (phase != PH_IDLE);
    assign carrier_en = car;
endmodule

// File: rtl/ir_pd_carrier.sv
module ir_pd_carrier #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             out
);
    logic [DIV_W-1:0] cnt;
    logic             sq;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            sq  <= 1'b0;
        end else if (cnt == div) begin
            cnt <= '0;
            sq  <= ~sq;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign out = en & sq;
endmodule

// File: rtl/ir_pd_tx.sv
module ir_pd_tx
    import ir_pd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               start,
    input  logic [BUF_W-1:0]   frame_bits,
    input  logic [LEN_W-1:0]   start_mark,
    input  logic [LEN_W-1:0]   start_space,
    input  logic [LEN_W-1:0]   one_mark,
    input  logic [LEN_W-1:0]   one_space,
    input  logic [LEN_W-1:0]   zero_mark,
    input  logic [LEN_W-1:0]   zero_space,
    input  logic [IDX_W-1:0]   bit_count,
    input  logic               stop_en,
    input  logic [REP_W-1:0]   rep_count,
    input  logic [GAP_W-1:0]   rep_gap,
    input  logic               sync_mode,
    input  logic               dbl_mode,
    input  logic [DIV_W-1:0]   carrier_div,
    output logic               busy,
    output logic               carrier_en,
    output logic               ir_out
);
    frame_cfg_t cfg_in;

    always_comb begin
        cfg_in.bits  = frame_bits;
        cfg_in.lead  = '{mark: start_mark, space: start_space};
        cfg_in.one   = '{mark: one_mark,   space: one_space};
        cfg_in.zero  = '{mark: zero_mark,  space: zero_space};
        cfg_in.nbits = bit_count;
        cfg_in.stop  = stop_en;
        cfg_in.reps  = rep_count;
        cfg_in.gap   = rep_gap;
        cfg_in.sync  = sync_mode;
        cfg_in.dbl   = dbl_mode;
    end

    ir_pd_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .start     (start),
        .cfg_in    (cfg_in),
        .busy      (busy),
        .carrier_en(carrier_en)
    );

    ir_pd_carrier #(.DIV_W(DIV_W)) u_car (
        .clk(clk),
        .rst(rst),
        .en (carrier_en),
        .div(carrier_div),
        .out(ir_out)
    );
endmodule

// File: rtl/ir_pd_tx_chk.sv
module ir_pd_tx_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic start,
    input logic busy,
    input logic carrier_en,
    input logic ir_out
);
    // R2: carrier gate moves only after a tick
    a_r2_gate_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(carrier_en));

    // R12: accepted start raises busy
    a_r12_busy_rise: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R1: idle engine keeps the carrier gate closed
    a_r1_idle_gate: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !carrier_en);

    // R11: no carrier on the output while idle
    a_r11_idle_out: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ir_out);

    // R7: the sequence ends during a space
    a_r7_end_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !carrier_en);
endmodule

bind ir_pd_tx ir_pd_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .start     (start),
    .busy      (busy),
    .carrier_en(carrier_en),
    .ir_out    (ir_out)
);

// File: tb/ir_pd_tx_bench.sv
module ir_pd_tx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic [39:0] frame_bits = '0;
    logic [7:0]  start_mark = '0, start_space = '0;
    logic [7:0]  one_mark = '0, one_space = '0;
    logic [7:0]  zero_mark = '0, zero_space = '0;
    logic [6:0]  bit_count = '0;
    logic        stop_en = 1'b0;
    logic [1:0]  rep_count = '0;
    logic [15:0] rep_gap = '0;
    logic        sync_mode = 1'b0, dbl_mode = 1'b0;
    logic [7:0]  carrier_div = 8'd2;
    logic        busy, carrier_en, ir_out;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    bit exp_lvl [0:4095];
    int n_exp;

    always #5 clk = ~clk;

    ir_pd_tx u_ir_pd_tx (
        .clk(clk), .rst(rst), .tick(tick), .start(start),
        .frame_bits(frame_bits),
        .start_mark(start_mark), .start_space(start_space),
        .one_mark(one_mark), .one_space(one_space),
        .zero_mark(zero_mark), .zero_space(zero_space),
        .bit_count(bit_count), .stop_en(stop_en), .rep_count(rep_count),
        .rep_gap(rep_gap), .sync_mode(sync_mode), .dbl_mode(dbl_mode),
        .carrier_div(carrier_div),
        .busy(busy), .carrier_en(carrier_en), .ir_out(ir_out)
    );

    task automatic check(input string req, input int act, input int exp_v);
        vectors++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic push(input bit lvl, input int len);
        for (int i = 0; i < len; i++) begin
            exp_lvl[n_exp] = lvl;
            n_exp++;
        end
    endtask

    // Expected tick-by-tick gate, built from the requirements
    task automatic build_exp();
        int frames;
        int lo, hi, j;
        bit v;
        n_exp  = 0;
        frames = (rep_count == 0) ? 1 : int'(rep_count);
        for (int f = 0; f < frames; f++) begin
            if (f > 0) push(1'b0, int'(rep_gap));
            if ((f == 0 || !dbl_mode) && start_mark != 0) begin
                push(1'b1, int'(start_mark));
                push(1'b0, int'(start_space));
            end
            lo = (dbl_mode && f > 0) ? 16 : 0;
            hi = (dbl_mode && f > 0) ? 2 * int'(bit_count) + 1 : int'(bit_count);
            for (int i = lo; i < hi; i++) begin
                if (sync_mode && i == 16) begin
                    push(1'b1, int'(zero_mark));
                    push(1'b0, int'(start_space));
                end else begin
                    j = (sync_mode && i > 16) ? i - 1 : i;
                    v = frame_bits[39 - j];
                    push(1'b1, v ? int'(one_mark) : int'(zero_mark));
                    push(1'b0, v ? int'(one_space) : int'(zero_space));
                end
            end
            if (stop_en) begin
                push(1'b1, int'(zero_mark));
                push(1'b0, (f == frames - 1) ? 255 : int'(zero_space));
            end
        end
    endtask

    // Start a frame and compare the gate after every tick
    task automatic run_frame(input string req, input int poke_at);
        int errs = 0;
        int bad_k = -1;
        int bad_a = 0;
        int early = 0;
        build_exp();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check({req, " R12 busy after start"}, busy, 1);
        for (int k = 0; k < n_exp; k++) begin
            tick = 1'b1;
            if (k == poke_at) begin
                start      = 1'b1;
                frame_bits = ~frame_bits;
                zero_mark  = zero_mark + 8'd3;
                one_space  = one_space + 8'd2;
            end
            @(negedge clk);
            tick  = 1'b0;
            start = 1'b0;
            if (carrier_en !== exp_lvl[k]) begin
                errs++;
                if (bad_k < 0) begin
                    bad_k = k;
                    bad_a = int'(carrier_en);
                end
            end
            if (k < n_exp - 1 && busy !== 1'b1) early++;
            @(negedge clk);
            @(negedge clk);
        end
        vectors++;
        if (errs != 0) begin
            fails++;
            $display("FAIL %s: tick %0d gate actual %0d expected %0d (%0d bad ticks)",
                     req, bad_k, bad_a, int'(exp_lvl[bad_k]), errs);
        end
        check({req, " R7 busy held until last tick"}, early, 0);
        check({req, " R7 busy clear at end"}, busy, 0);
        check({req, " R11 output low when idle"}, ir_out, 0);
    endtask

    task automatic set_common();
        start_mark = 8'd4; start_space = 8'd3;
        one_mark   = 8'd1; one_space   = 8'd3;
        zero_mark  = 8'd1; zero_space  = 8'd1;
        stop_en = 1'b0; rep_count = 2'd1; rep_gap = 16'd6;
        sync_mode = 1'b0; dbl_mode = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset busy", busy, 0);
        check("R1 reset gate", carrier_en, 0);
        check("R1 reset output", ir_out, 0);
    endtask

    task automatic t_basic();
        set_common();
        frame_bits = 40'hA5_3C_00_00_00;
        bit_count  = 7'd12;
        run_frame("R2 R3 R4 basic frame", -1);
    endtask

    task automatic t_no_start_stop();
        set_common();
        start_mark = 8'd0; start_space = 8'd0;
        stop_en    = 1'b1;
        frame_bits = 40'h6E_00_00_00_00;
        bit_count  = 7'd7;
        run_frame("R3 R5 R6 no start bit, stop trailer", -1);
    endtask

    task automatic t_repeat();
        set_common();
        start_mark = 8'd2; start_space = 8'd2;
        zero_space = 8'd2;
        stop_en    = 1'b1;
        rep_count  = 2'd3;
        rep_gap    = 16'd5;
        frame_bits = 40'h90_00_00_00_00;
        bit_count  = 7'd4;
        run_frame("R5 R6 R7 three frames with gaps", -1);
    endtask

    task automatic t_sync();
        set_common();
        sync_mode  = 1'b1;
        start_space = 8'd5;
        frame_bits = 40'h5A_C3_96_0F_00;
        bit_count  = 7'd25;
        run_frame("R8 sync bit after address", -1);
    endtask

    task automatic t_double();
        set_common();
        start_mark = 8'd3; start_space = 8'd2;
        dbl_mode   = 1'b1;
        stop_en    = 1'b1;
        rep_count  = 2'd2;
        rep_gap    = 16'd7;
        frame_bits = 40'hF0_0F_A5_3C_00;
        bit_count  = 7'd12;
        run_frame("R9 second frame from bit 16", -1);
    endtask

    task automatic t_busy_ignore();
        set_common();
        frame_bits = 40'hC3_5A_00_00_00;
        bit_count  = 7'd10;
        run_frame("R10 start and inputs ignored while busy", 9);
    endtask

    task automatic t_carrier();
        int errs = 0;
        int exp_v;
        set_common();
        start_mark  = 8'd100;
        carrier_div = 8'd2;
        bit_count   = 7'd4;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; tick = 1'b1;
        for (int n = 0; n < 18; n++) begin
            @(negedge clk);
            tick  = 1'b0;
            exp_v = (n / (int'(carrier_div) + 1)) % 2;
            if (int'(ir_out) != exp_v) errs++;
        end
        check("R11 carrier half period", errs, 0);
        check("R2 gate on during start mark", carrier_en, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid-frame busy", busy, 0);
        check("R1 reset mid-frame gate", carrier_en, 0);
        check("R1 reset mid-frame output", ir_out, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_no_start_stop();
        t_repeat();
        t_sync();
        t_double();
        t_busy_ignore();
        t_carrier();
        t_basic();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule